// File: doc/BRIEF.md
# SPI Register-File Slave

This block is the serial host port of a measurement front end. An external SPI master reaches eight byte-wide registers through it: one configuration byte, a two-byte upper threshold, a two-byte lower threshold, and three bytes that the core owns and the host may only read (a two-byte measurement result and a status byte). The block keeps the host-writable bytes itself and drives their values to the core. It also pulses a write strobe to the core for every byte it accepts. A request bit in the configuration byte becomes a single-cycle start pulse, and that pulse fires only when the chip select that ended the transaction has been released.

The serial pins are oversampled by the system clock through a synchronizer. Edges of the serial clock are found in the system clock domain. The idle level of the serial clock is sampled each time chip select falls, so masters using clock polarity 0 or clock polarity 1 are both accepted, in each case with output on the leading edge and input on the trailing edge. The first byte of a transaction selects the direction and the start register. The following bytes move data, and the register pointer advances after each byte. The output driver is enabled only while a read byte is being shifted.

Top module: `spi_regfile`

## Requirements
- R1: After reset, the configuration byte reads 00h, the upper threshold is FFFFh, the lower threshold is 0000h, `spi_sdo_oe` is low, and neither `wr_stb` nor `oneshot_go` is asserted.
- R2: The level of `spi_sclk` at the moment `spi_csn` falls is taken as the idle level. Input bits are taken on each return of the clock to that level, and output bits change on each departure from it. A master idling low and a master idling high get identical results.
- R3: The first byte after `spi_csn` falls is an address, MSB first. If its bit 7 is 1, the later bytes are writes; if it is 0, they are reads. The low three bits pick the register: 0 configuration, 1 measurement high byte, 2 measurement low byte, 3 and 4 upper threshold high and low byte, 5 and 6 lower threshold high and low byte, 7 status.
- R4: While `spi_csn` stays low, the register pointer advances by one after every data byte, so a burst reaches consecutive registers.
- R5: The pointer keeps bit 7 and wraps its low seven bits, so it goes from 7Fh to 00h and from FFh to 80h.
- R6: A read from an address 08h to 7Fh returns FFh.
- R7: A write addressed to 81h, 82h, 87h or 88h to FFh changes no stored byte and produces no write strobe.
- R8: Each accepted write byte raises `wr_stb` for exactly one system clock cycle, with `wr_idx` holding the register index and `wr_data` the byte. Only indices 0, 3, 4, 5 and 6 ever appear.
- R9: `spi_sdo_oe` stays low during the address byte, during write transactions, and while `spi_csn` is high. During read data bytes it is high, and `spi_sdo` carries the addressed byte MSB first.
- R10: A configuration write with bit 5 set stores that bit as 0. Exactly one `oneshot_go` pulse follows the rising edge of `spi_csn` that ends the transaction, and none comes while `spi_csn` is low, even in a multi-byte write.
- R11: If `spi_csn` rises before the eighth bit of a byte, the partial byte is discarded, and the next transaction starts again with an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from the master |
| spi_sdo | output | 1 | Serial data to the master |
| spi_sdo_oe | output | 1 | Output enable for the tristate driver of `spi_sdo` |
| ro_meas_hi | input | 8 | Measurement high byte from the core (index 1) |
| ro_meas_lo | input | 8 | Measurement low byte from the core (index 2) |
| ro_status | input | 8 | Status byte from the core (index 7) |
| cfg_q | output | 8 | Stored configuration byte |
| thr_hi_q | output | 16 | Upper threshold, index 3 in the high byte |
| thr_lo_q | output | 16 | Lower threshold, index 5 in the high byte |
| wr_stb | output | 1 | One-cycle strobe for an accepted write byte |
| wr_idx | output | 3 | Register index of the strobed write |
| wr_data | output | 8 | Data of the strobed write |
| oneshot_go | output | 1 | One-cycle start pulse after the transaction ends |

## Verification
On every cycle, the assertions check the following: the output driver stays off while chip select is high, strobes last one cycle and carry only writable indices, the stored configuration and threshold bytes change only right after a matching strobe, and the start pulse is a single cycle that falls only while chip select is high. Some behaviour needs a whole serial transaction to show, and only the directed scenarios cover it. This includes polarity detection in both modes, decoding of the address byte, burst increments and the two wrap points, the FFh fill for unmapped reads, the MSB-first order of read data, and the discard of a byte cut short.

// File: rtl/spirf_pkg.sv
package spirf_pkg;
   localparam int NUM_REGS    = 8;
   localparam int IDX_W       = $clog2(NUM_REGS);
   localparam int IDX_CFG     = 0;
   localparam int IDX_MEAS_HI = 1;
   localparam int IDX_MEAS_LO = 2;
   localparam int IDX_UTH_HI  = 3;
   localparam int IDX_UTH_LO  = 4;
   localparam int IDX_LTH_HI  = 5;
   localparam int IDX_LTH_LO  = 6;
   localparam int IDX_STAT    = 7;

   typedef logic [7:0] byte_t;
   typedef enum logic {PH_ADDR, PH_DATA} phase_e;

   // pointer advance: direction bit kept, low seven bits wrap
   function automatic byte_t ptr_next(input byte_t a);
      return {a[7], a[6:0] + 7'd1};
   endfunction

   function automatic logic in_window(input byte_t a);
      return a[6:IDX_W] == '0;
   endfunction

   function automatic logic host_writable(input int idx);
      return (idx == IDX_CFG) || (idx == IDX_UTH_HI) || (idx == IDX_UTH_LO) ||
             (idx == IDX_LTH_HI) || (idx == IDX_LTH_LO);
   endfunction
endpackage

// File: rtl/spirf_sync.sv
module spirf_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/spirf_engine.sv
module spirf_engine
   import spirf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  csn_s,
   input  logic  sclk_s,
   input  logic  sdi_s,
   input  byte_t rd_byte,
   output byte_t rd_addr,
   output logic  sdo,
   output logic  sdo_oe,
   output logic  wr_pulse,
   output byte_t wr_addr,
   output byte_t wr_byte,
   output logic  cs_rise
);
   logic   csn_d, sclk_d, cpol, is_wr;
   phase_e phase;
   byte_t  ptr, tx_sh;
   logic [6:0] rx_sh;
   logic [2:0] bit_cnt;

   logic  cs_fall, active, sclk_chg, smp_edge, lead_edge;
   byte_t rx_full;

   assign cs_fall   = csn_d & ~csn_s;
   assign cs_rise   = ~csn_d & csn_s;
   assign active    = ~csn_d & ~csn_s;
   assign sclk_chg  = sclk_s ^ sclk_d;
   assign smp_edge  = active & sclk_chg & (sclk_s == cpol);
   assign lead_edge = active & sclk_chg & (sclk_s != cpol);
   assign rx_full   = {rx_sh, sdi_s};
   assign rd_addr   = (phase == PH_ADDR) ? rx_full : ptr_next(ptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         csn_d    <= 1'b1;
         sclk_d   <= 1'b0;
         cpol     <= 1'b0;
         is_wr    <= 1'b0;
         phase    <= PH_ADDR;
         ptr      <= '0;
         tx_sh    <= '0;
         rx_sh    <= '0;
         bit_cnt  <= '0;
         sdo      <= 1'b0;
         sdo_oe   <= 1'b0;
         wr_pulse <= 1'b0;
         wr_addr  <= '0;
         wr_byte  <= '0;
      end else begin
         csn_d    <= csn_s;
         sclk_d   <= sclk_s;
         wr_pulse <= 1'b0;
         if (cs_fall) begin
            cpol    <= sclk_s;
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            sdo_oe  <= 1'b0;
         end
         if (cs_rise) begin
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            sdo_oe  <= 1'b0;
         end
         if (smp_edge) begin
            rx_sh   <= rx_full[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               if (phase == PH_ADDR) begin
                  ptr   <= rx_full;
                  is_wr <= rx_full[7];
                  phase <= PH_DATA;
                  if (!rx_full[7]) tx_sh <= rd_byte;
               end else if (is_wr) begin
                  wr_pulse <= 1'b1;
                  wr_addr  <= ptr;
                  wr_byte  <= rx_full;
                  ptr      <= ptr_next(ptr);
               end else begin
                  ptr   <= ptr_next(ptr);
                  tx_sh <= rd_byte;
               end
            end
         end
         if (lead_edge && phase == PH_DATA && !is_wr) begin
            sdo    <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
            sdo_oe <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spirf_regs.sv
module spirf_regs
   import spirf_pkg::*;
#(
   parameter int          ONESHOT_BIT = 5,
   parameter logic [7:0]  CFG_RST     = 8'h00,
   parameter logic [15:0] UTH_RST     = 16'hFFFF,
   parameter logic [15:0] LTH_RST     = 16'h0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_pulse,
   input  byte_t            wr_addr,
   input  byte_t            wr_byte,
   input  byte_t            rd_addr,
   input  logic             cs_rise,
   input  byte_t            ro_meas_hi,
   input  byte_t            ro_meas_lo,
   input  byte_t            ro_status,
   output byte_t            rd_byte,
   output byte_t            cfg_q,
   output logic [15:0]      thr_hi_q,
   output logic [15:0]      thr_lo_q,
   output logic             wr_stb,
   output logic [IDX_W-1:0] wr_idx,
   output byte_t            wr_data,
   output logic             oneshot_go
);
   localparam byte_t OS_MASK = ~(byte_t'(1) << ONESHOT_BIT);

   function automatic byte_t reset_of(input int idx);
      case (idx)
         IDX_CFG:    return CFG_RST & OS_MASK;
         IDX_UTH_HI: return UTH_RST[15:8];
         IDX_UTH_LO: return UTH_RST[7:0];
         IDX_LTH_HI: return LTH_RST[15:8];
         IDX_LTH_LO: return LTH_RST[7:0];
         default:    return '0;
      endcase
   endfunction

   logic [NUM_REGS-1:0][7:0] bank;
   logic [NUM_REGS-1:0]      wr_ok;
   logic                     os_pend;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_bank
      assign wr_ok[i] = host_writable(i);
      if (host_writable(i)) begin : g_rw
         localparam byte_t RV = reset_of(i);
         byte_t q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= RV;
            else if (wr_stb && wr_idx == IDX_W'(i))
               q <= (i == IDX_CFG) ? (wr_byte & OS_MASK) : wr_byte;
         assign bank[i] = q;
      end else if (i == IDX_MEAS_HI) begin : g_mh
         assign bank[i] = ro_meas_hi;
      end else if (i == IDX_MEAS_LO) begin : g_ml
         assign bank[i] = ro_meas_lo;
      end else begin : g_st
         assign bank[i] = ro_status;
      end
   end

   assign wr_idx  = wr_addr[IDX_W-1:0];
   assign wr_data = wr_byte;
   assign wr_stb  = wr_pulse & wr_addr[7] & in_window(wr_addr) & wr_ok[wr_idx];

   assign rd_byte = (!rd_addr[7] && in_window(rd_addr)) ? bank[rd_addr[IDX_W-1:0]] : 8'hFF;

   assign cfg_q    = bank[IDX_CFG];
   assign thr_hi_q = {bank[IDX_UTH_HI], bank[IDX_UTH_LO]};
   assign thr_lo_q = {bank[IDX_LTH_HI], bank[IDX_LTH_LO]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         os_pend    <= 1'b0;
         oneshot_go <= 1'b0;
      end else begin
         oneshot_go <= 1'b0;
         if (wr_stb && wr_idx == IDX_W'(IDX_CFG) && wr_byte[ONESHOT_BIT])
            os_pend <= 1'b1;
         if (cs_rise) begin
            oneshot_go <= os_pend;
            os_pend    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
   import spirf_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          ONESHOT_BIT = 5,
   parameter logic [7:0]  CFG_RST     = 8'h00,
   parameter logic [15:0] UTH_RST     = 16'hFFFF,
   parameter logic [15:0] LTH_RST     = 16'h0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        spi_sclk,
   input  logic        spi_csn,
   input  logic        spi_sdi,
   output logic        spi_sdo,
   output logic        spi_sdo_oe,
   input  logic [7:0]  ro_meas_hi,
   input  logic [7:0]  ro_meas_lo,
   input  logic [7:0]  ro_status,
   output logic [7:0]  cfg_q,
   output logic [15:0] thr_hi_q,
   output logic [15:0] thr_lo_q,
   output logic        wr_stb,
   output logic [2:0]  wr_idx,
   output logic [7:0]  wr_data,
   output logic        oneshot_go
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ONESHOT_BIT < 0 || ONESHOT_BIT > 7) begin : g_bad_os
      $error("ONESHOT_BIT must select a bit of the configuration byte");
   end
   if (IDX_W != 3) begin : g_bad_idx
      $error("register index width must match the 3-bit strobe port");
   end

   logic [2:0] sync_q;
   logic       csn_s, sclk_s, sdi_s;
   logic       wr_pulse, cs_rise;
   byte_t      wr_addr, wr_byte, rd_addr, rd_byte;

   spirf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d ({spi_csn, spi_sclk, spi_sdi}),
      .q (sync_q)
   );
   assign {csn_s, sclk_s, sdi_s} = sync_q;

   spirf_engine u_engine (
      .clk (clk),
      .rst_n (rst_n),
      .csn_s (csn_s),
      .sclk_s (sclk_s),
      .sdi_s (sdi_s),
      .rd_byte (rd_byte),
      .rd_addr (rd_addr),
      .sdo (spi_sdo),
      .sdo_oe (spi_sdo_oe),
      .wr_pulse (wr_pulse),
      .wr_addr (wr_addr),
      .wr_byte (wr_byte),
      .cs_rise (cs_rise)
   );

   spirf_regs #(
      .ONESHOT_BIT (ONESHOT_BIT),
      .CFG_RST (CFG_RST),
      .UTH_RST (UTH_RST),
      .LTH_RST (LTH_RST)
   ) u_regs (
      .clk (clk),
      .rst_n (rst_n),
      .wr_pulse (wr_pulse),
      .wr_addr (wr_addr),
      .wr_byte (wr_byte),
      .rd_addr (rd_addr),
      .cs_rise (cs_rise),
      .ro_meas_hi (ro_meas_hi),
      .ro_meas_lo (ro_meas_lo),
      .ro_status (ro_status),
      .rd_byte (rd_byte),
      .cfg_q (cfg_q),
      .thr_hi_q (thr_hi_q),
      .thr_lo_q (thr_lo_q),
      .wr_stb (wr_stb),
      .wr_idx (wr_idx),
      .wr_data (wr_data),
      .oneshot_go (oneshot_go)
   );
endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        csn_s,
   input logic        sdo_oe,
   input logic        wr_stb,
   input logic [2:0]  wr_idx,
   input logic [7:0]  cfg_q,
   input logic [15:0] thr_hi_q,
   input logic [15:0] thr_lo_q,
   input logic        oneshot_go
);
   AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (csn_s && $past(csn_s)) |-> !sdo_oe);  // R9

   AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);  // R8

   AST_STB_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (wr_idx == 3'd0 || wr_idx == 3'd3 || wr_idx == 3'd4 ||
                  wr_idx == 3'd5 || wr_idx == 3'd6));  // R7

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_stb && wr_idx == 3'd0) |-> $stable(cfg_q));  // R7

   AST_UTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_stb && (wr_idx == 3'd3 || wr_idx == 3'd4)) |-> $stable(thr_hi_q));  // R7

   AST_LTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_stb && (wr_idx == 3'd5 || wr_idx == 3'd6)) |-> $stable(thr_lo_q));  // R7

   AST_GO_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      oneshot_go |-> csn_s);  // R10

   AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      oneshot_go |=> !oneshot_go);  // R10
endmodule

bind spi_regfile spi_regfile_chk u_chk (
   .clk (clk),
   .rst_n (rst_n),
   .csn_s (csn_s),
   .sdo_oe (spi_sdo_oe),
   .wr_stb (wr_stb),
   .wr_idx (wr_idx),
   .cfg_q (cfg_q),
   .thr_hi_q (thr_hi_q),
   .thr_lo_q (thr_lo_q),
   .oneshot_go (oneshot_go)
);

// File: tb/spi_regfile_bench.sv
`timescale 1ns/1ps
module spi_regfile_bench;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0;
   logic spi_sdo, spi_sdo_oe;
   logic [7:0] ro_meas_hi = 8'h00, ro_meas_lo = 8'h00, ro_status = 8'h00;
   logic [7:0] cfg_q, wr_data;
   logic [15:0] thr_hi_q, thr_lo_q;
   logic wr_stb, oneshot_go;
   logic [2:0] wr_idx;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0] tx_buf [16];
   logic [7:0] rx_buf [16];
   int oe_bad = 0;

   int stb_cnt = 0;
   logic [2:0] stb_idx [16];
   logic [7:0] stb_dat [16];
   int go_cnt = 0, go_early = 0;

   always #2 clk = ~clk;

   spi_regfile u_spi_regfile (
      .clk, .rst_n, .spi_sclk, .spi_csn, .spi_sdi, .spi_sdo, .spi_sdo_oe,
      .ro_meas_hi, .ro_meas_lo, .ro_status, .cfg_q, .thr_hi_q, .thr_lo_q,
      .wr_stb, .wr_idx, .wr_data, .oneshot_go
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         if (stb_cnt < 16) begin
            stb_idx[stb_cnt] = wr_idx;
            stb_dat[stb_cnt] = wr_data;
         end
         stb_cnt++;
      end
      if (oneshot_go) begin
         go_cnt++;
         if (!spi_csn) go_early++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // cut_bit < 0: full transfer; otherwise chip select rises before that bit
   task automatic spi_xfer(input logic cpol, input int nbytes, input int cut_bit);
      bit stop = 0;
      bit is_rd = (tx_buf[0][7] == 1'b0);
      oe_bad = 0;
      spi_sclk = cpol;
      wait_cyc(HALF);
      spi_csn = 1'b0;
      wait_cyc(HALF);
      for (int b = 0; b < nbytes && !stop; b++) begin
         for (int k = 7; k >= 0; k--) begin
            if (cut_bit >= 0 && (b * 8 + 7 - k) == cut_bit) begin
               stop = 1;
               break;
            end
            spi_sclk = ~cpol;
            spi_sdi  = tx_buf[b][k];
            wait_cyc(HALF);
            rx_buf[b][k] = spi_sdo;
            if ((b == 0 || !is_rd) && spi_sdo_oe) oe_bad++;
            if (b > 0 && is_rd && !spi_sdo_oe) oe_bad++;
            spi_sclk = cpol;
            wait_cyc(HALF);
         end
      end
      spi_csn = 1'b1;
      wait_cyc(4 * HALF);
   endtask

   task automatic t_reset();
      chk(cfg_q == 8'h00, "R1 cfg reset", cfg_q, 8'h00);
      chk(thr_hi_q == 16'hFFFF, "R1 upper threshold reset", thr_hi_q, 16'hFFFF);
      chk(thr_lo_q == 16'h0000, "R1 lower threshold reset", thr_lo_q, 16'h0000);
      chk(!spi_sdo_oe && !wr_stb && !oneshot_go, "R1 outputs idle",
          {spi_sdo_oe, wr_stb, oneshot_go}, 0);
   endtask

   task automatic t_write_mode_low();
      int s0 = stb_cnt;
      tx_buf[0] = 8'h80; tx_buf[1] = 8'h81;
      spi_xfer(1'b0, 2, -1);
      chk(cfg_q == 8'h81, "R2 R3 write with idle-low clock", cfg_q, 8'h81);
      chk(stb_cnt == s0 + 1 && stb_idx[s0] == 3'd0 && stb_dat[s0] == 8'h81,
          "R8 strobe index and data", {stb_cnt - s0, 5'(stb_idx[s0]), stb_dat[s0]}, {32'd1, 5'd0, 8'h81});
      chk(oe_bad == 0, "R9 driver off during write", oe_bad, 0);
   endtask

   task automatic t_read_mode_high();
      tx_buf[0] = 8'h00; tx_buf[1] = 8'h00;
      spi_xfer(1'b1, 2, -1);
      chk(rx_buf[1] == 8'h81, "R2 R9 read with idle-high clock", rx_buf[1], 8'h81);
      chk(oe_bad == 0, "R9 driver only during read data", oe_bad, 0);
      chk(!spi_sdo_oe, "R9 driver off after chip select", spi_sdo_oe, 0);
   endtask

   task automatic t_burst();
      int s0 = stb_cnt;
      tx_buf[0] = 8'h83; tx_buf[1] = 8'h12; tx_buf[2] = 8'h34;
      tx_buf[3] = 8'h56; tx_buf[4] = 8'h78;
      spi_xfer(1'b1, 5, -1);
      chk(thr_hi_q == 16'h1234, "R4 burst write upper", thr_hi_q, 16'h1234);
      chk(thr_lo_q == 16'h5678, "R4 burst write lower", thr_lo_q, 16'h5678);
      chk(stb_cnt == s0 + 4 && stb_idx[s0] == 3'd3 && stb_idx[s0 + 3] == 3'd6,
          "R8 burst strobes", stb_cnt - s0, 4);
      tx_buf[0] = 8'h03;
      spi_xfer(1'b0, 5, -1);
      chk({rx_buf[1], rx_buf[2], rx_buf[3], rx_buf[4]} == 32'h12345678,
          "R4 burst read", {rx_buf[1], rx_buf[2], rx_buf[3], rx_buf[4]}, 32'h12345678);
   endtask

   task automatic t_core_bytes();
      ro_meas_hi = 8'h9A; ro_meas_lo = 8'hBC; ro_status = 8'hDE;
      tx_buf[0] = 8'h01;
      spi_xfer(1'b0, 3, -1);
      chk({rx_buf[1], rx_buf[2]} == 16'h9ABC, "R3 measurement bytes", {rx_buf[1], rx_buf[2]}, 16'h9ABC);
      tx_buf[0] = 8'h07;
      spi_xfer(1'b1, 3, -1);
      chk(rx_buf[1] == 8'hDE, "R3 status byte", rx_buf[1], 8'hDE);
      chk(rx_buf[2] == 8'hFF, "R6 unmapped read after status", rx_buf[2], 8'hFF);
   endtask

   task automatic t_wrap();
      int s0;
      tx_buf[0] = 8'h7F;
      spi_xfer(1'b0, 3, -1);
      chk(rx_buf[1] == 8'hFF, "R6 read at 7Fh", rx_buf[1], 8'hFF);
      chk(rx_buf[2] == 8'h81, "R5 read wrap to 00h", rx_buf[2], 8'h81);
      s0 = stb_cnt;
      tx_buf[0] = 8'hFF; tx_buf[1] = 8'h11; tx_buf[2] = 8'h42;
      spi_xfer(1'b1, 3, -1);
      chk(cfg_q == 8'h42, "R5 write wrap to 80h", cfg_q, 8'h42);
      chk(stb_cnt == s0 + 1, "R7 no strobe at FFh", stb_cnt - s0, 1);
   endtask

   task automatic t_readonly_write();
      int s0 = stb_cnt;
      tx_buf[0] = 8'h81; tx_buf[1] = 8'h55; tx_buf[2] = 8'h66; tx_buf[3] = 8'hAA;
      spi_xfer(1'b0, 4, -1);
      chk(stb_cnt == s0 + 1 && stb_idx[s0] == 3'd3, "R7 only index 3 strobed", stb_cnt - s0, 1);
      chk(thr_hi_q == 16'hAA34, "R7 write after read-only bytes", thr_hi_q, 16'hAA34);
      tx_buf[0] = 8'h87; tx_buf[1] = 8'h77;
      spi_xfer(1'b1, 2, -1);
      chk(stb_cnt == s0 + 1 && cfg_q == 8'h42, "R7 write to 87h ignored", stb_cnt - s0, 1);
      tx_buf[0] = 8'h01;
      spi_xfer(1'b0, 3, -1);
      chk({rx_buf[1], rx_buf[2]} == 16'h9ABC, "R7 core bytes unchanged", {rx_buf[1], rx_buf[2]}, 16'h9ABC);
   endtask

   task automatic t_oneshot();
      int g0 = go_cnt;
      tx_buf[0] = 8'h80; tx_buf[1] = 8'hA0; tx_buf[2] = 8'h00;
      spi_xfer(1'b0, 3, -1);
      chk(go_early == 0, "R10 no pulse while selected", go_early, 0);
      chk(go_cnt == g0 + 1, "R10 one pulse after release", go_cnt - g0, 1);
      chk(cfg_q == 8'h80, "R10 request bit stored as 0", cfg_q, 8'h80);
      tx_buf[1] = 8'h81;
      spi_xfer(1'b1, 2, -1);
      chk(go_cnt == g0 + 1, "R10 no pulse without request", go_cnt - g0, 1);
   endtask

   task automatic t_abort();
      int s0 = stb_cnt;
      tx_buf[0] = 8'h80; tx_buf[1] = 8'hFF;
      spi_xfer(1'b0, 2, 12);
      chk(cfg_q == 8'h81 && stb_cnt == s0, "R11 partial byte discarded", cfg_q, 8'h81);
      tx_buf[0] = 8'h00;
      spi_xfer(1'b1, 2, -1);
      chk(rx_buf[1] == 8'h81, "R11 fresh address after abort", rx_buf[1], 8'h81);
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      t_reset();
      t_write_mode_low();
      t_read_mode_high();
      t_burst();
      t_core_bytes();
      t_wrap();
      t_readonly_write();
      t_oneshot();
      t_abort();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule